// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block watches the running clock fields of a real-time clock (hundredths, seconds, minutes, hours, and day of week or date of month) and compares them against five alarm bytes. Each alarm byte can drop its field out of the comparison, which gives repeat rates from every hundredth of a second up to once a week or once a month. The hundredths byte has its own masking codes: it can match every tick, or match on the tenths digit alone.

The compare runs once per hundredths update strobe. A hit sets a sticky alarm flag one cycle later. The enables have no effect on this. Software clears the flag by writing 0 to it. An active-low interrupt request is driven from the flag through an enable bit and an interrupt/square-wave mode bit. On backup power the request is released unless a battery-output enable bit is set.

Top module: `alarm_match_unit`

## Requirements
- R1: When the hundredths alarm byte holds a normal BCD value (high nibble 0-9), the hundredths field matches only when all eight bits equal the current hundredths byte.
- R2: A hundredths alarm byte of 8'hFF matches on every tick.
- R3: A hundredths alarm byte of 8'hF0 to 8'hF9 matches when the current tenths digit (current hundredths bits 7:4) equals the byte's low nibble. The hundredths digit is ignored.
- R4: Bit 7 of the seconds, minutes, hours and day/date alarm bytes is a mask. When it is 1, that field is excluded. When it is 0, bits 6:0 must equal the current field (bits 5:0 for day/date). With all masks 0, a hit needs every field to match.
- R5: Bit 6 of the day/date alarm byte selects the target: 0 compares with the date of month, 1 compares with the day of week.
- R6: A hit while tick is 1 sets alarm_flag on the next cycle, whatever the enable bits hold. With tick at 0, the flag is never set.
- R7: A write to status (wr_sel 6) with wr_data bit 0 at 0 clears alarm_flag. With bit 0 at 1 the flag is unchanged. A hit in the same cycle as a clear wins.
- R8: On main power, irq_low is 1 exactly when alarm_flag, control bit 0 (alarm interrupt enable) and control bit 2 (1 = interrupt mode, 0 = square-wave mode) are all 1. It follows register changes combinationally.
- R9: With batt_mode at 1, irq_low is 0 unless control bit 5 (battery output enable) is 1. If bit 5 is 1, R8 applies.
- R10: After reset, all alarm bytes, all control bits and alarm_flag are 0, and irq_low is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Hundredths update strobe, one cycle wide |
| cur_hund | input | 8 | Current hundredths, BCD |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours byte (bit 6 is the 12/24 mode bit) |
| cur_day | input | 8 | Current day of week |
| cur_date | input | 8 | Current date of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Target register: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day/date, 5 control, 6 status, 7 none |
| wr_data | input | 8 | Write data |
| batt_mode | input | 1 | 1 while running on backup power |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_low | output | 1 | 1 = pull the open-drain interrupt line low; 0 = released |

## Verification
Several properties are checked on every cycle:
- A strobed hit always raises the flag on the next cycle.
- The flag never drops without a clearing write.
- The flag never rises without a strobe.
- The interrupt line is never pulled without the flag.
- The interrupt line is never pulled on backup power without the battery enable.
- A fully masked alarm always hits on a tick.

Only the bench scenarios can show whether each mask code and the day/date select compare the right digits. They drive random alarm bytes and biased time fields and compare against a reference function. The same applies to the clear-versus-set priority and to the full enable truth table.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_ALM   = 5;
  localparam int NUM_PLAIN = 3;

  localparam logic [2:0] SEL_HUND    = 3'd0;
  localparam logic [2:0] SEL_DAYDATE = 3'd4;
  localparam logic [2:0] SEL_CTRL    = 3'd5;
  localparam logic [2:0] SEL_STAT    = 3'd6;

  localparam int CTL_AIE  = 0;
  localparam int CTL_MODE = 2;
  localparam int CTL_BATT = 5;
  localparam int STAT_FLAG = 0;

  typedef struct packed {
    logic batt_en;
    logic int_mode;
    logic aie;
  } ctrl_t;
endpackage

// File: rtl/alm_regs.sv
module alm_regs
  import alm_pkg::*;
#(
  parameter int W = BYTE_W,
  parameter int N = NUM_ALM
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [W-1:0]       wr_data,
  input  logic               set_flag,
  output logic [N-1:0][W-1:0] alm,
  output ctrl_t              ctrl,
  output logic               flag
);
  logic [N-1:0][W-1:0] alm_q, alm_d;
  ctrl_t ctrl_q, ctrl_d;
  logic  flag_q, flag_d;
  logic  clr_req;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      alm_d[i] = (wr_en && (wr_sel == 3'(i))) ? wr_data : alm_q[i];
    end
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && wr_sel == SEL_CTRL) begin
      ctrl_d.aie      = wr_data[CTL_AIE];
      ctrl_d.int_mode = wr_data[CTL_MODE];
      ctrl_d.batt_en  = wr_data[CTL_BATT];
    end
  end

  assign clr_req = wr_en && (wr_sel == SEL_STAT) && !wr_data[STAT_FLAG];

  always_comb begin
    flag_d = flag_q;
    if (set_flag)     flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q  <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      alm_q  <= alm_d;
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  assign alm  = alm_q;
  assign ctrl = ctrl_q;
  assign flag = flag_q;

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_flag |=> flag);
  // R6
  flag_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !set_flag) |=> !flag);
  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);
endmodule

// File: rtl/alm_compare.sv
module alm_compare
  import alm_pkg::*;
#(
  parameter int W = BYTE_W,
  parameter int N = NUM_ALM,
  parameter int P = NUM_PLAIN
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [N-1:0][W-1:0] alm,
  input  logic [W-1:0]        cur_hund,
  input  logic [P-1:0][W-1:0] cur_plain,
  input  logic [W-1:0]        cur_day,
  input  logic [W-1:0]        cur_date,
  output logic                hit
);
  localparam int NIB = W / 2;
  localparam int DD_W = W - 2;

  logic            hund_ok;
  logic [P-1:0]    plain_ok;
  logic            dd_ok;
  logic [W-1:0]    dd_cur;
  logic [W-1:0]    ah;

  assign ah = alm[0];

  always_comb begin
    if (ah == {W{1'b1}})
      hund_ok = 1'b1;
    else if (ah[W-1:NIB] == {NIB{1'b1}})
      hund_ok = (cur_hund[W-1:NIB] == ah[NIB-1:0]);
    else
      hund_ok = (cur_hund == ah);
  end

  for (genvar g = 0; g < P; g++) begin : g_plain
    logic [W-1:0] a;
    assign a = alm[g+1];
    assign plain_ok[g] = a[W-1] || (cur_plain[g] == {1'b0, a[W-2:0]});
  end

  assign dd_cur = alm[N-1][W-2] ? cur_day : cur_date;
  assign dd_ok  = alm[N-1][W-1] ||
                  (dd_cur == {2'b00, alm[N-1][DD_W-1:0]});

  assign hit = tick && hund_ok && (&plain_ok) && dd_ok;

  // R2
  fully_masked_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ah == {W{1'b1}} && alm[1][W-1] && alm[2][W-1] &&
     alm[3][W-1] && alm[N-1][W-1]) |-> hit);
  // R6
  no_tick_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !hit);
endmodule

// File: rtl/alm_irq.sv
module alm_irq
  import alm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flag,
  input  ctrl_t ctrl,
  input  logic  batt_mode,
  output logic  irq_low
);
  logic int_req;
  logic out_allowed;

  assign int_req     = flag && ctrl.aie && ctrl.int_mode;
  assign out_allowed = !batt_mode || ctrl.batt_en;
  assign irq_low     = int_req && out_allowed;

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_low |-> flag);
  // R9
  batt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_mode && !ctrl.batt_en) |-> !irq_low);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alm_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cur_hund,
  input  logic [W-1:0] cur_sec,
  input  logic [W-1:0] cur_min,
  input  logic [W-1:0] cur_hour,
  input  logic [W-1:0] cur_day,
  input  logic [W-1:0] cur_date,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         batt_mode,
  output logic         alarm_flag,
  output logic         irq_low
);
  logic [NUM_ALM-1:0][W-1:0]   alm;
  logic [NUM_PLAIN-1:0][W-1:0] cur_plain;
  ctrl_t ctrl;
  logic  hit;

  assign cur_plain = {cur_hour, cur_min, cur_sec};

  alm_regs #(.W(W), .N(NUM_ALM)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .set_flag(hit), .alm(alm), .ctrl(ctrl),
    .flag(alarm_flag)
  );

  alm_compare #(.W(W), .N(NUM_ALM), .P(NUM_PLAIN)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .alm(alm),
    .cur_hund(cur_hund), .cur_plain(cur_plain),
    .cur_day(cur_day), .cur_date(cur_date), .hit(hit)
  );

  alm_irq u_irq (
    .clk(clk), .rst_n(rst_n), .flag(alarm_flag), .ctrl(ctrl),
    .batt_mode(batt_mode), .irq_low(irq_low)
  );
endmodule

// File: tb/alarm_match_unit_tb.sv
module alarm_match_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] cur_hund = '0, cur_sec = '0, cur_min = '0, cur_hour = '0;
  logic [7:0] cur_day = '0, cur_date = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic batt_mode = 1'b0;
  logic alarm_flag, irq_low;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] a_h, a_s, a_m, a_hr, a_dd;

  always #4 clk = ~clk;

  alarm_match_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cur_hund(cur_hund),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_day(cur_day), .cur_date(cur_date), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .batt_mode(batt_mode),
    .alarm_flag(alarm_flag), .irq_low(irq_low)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      3'd0: a_h = d;
      3'd1: a_s = d;
      3'd2: a_m = d;
      3'd3: a_hr = d;
      3'd4: a_dd = d;
      default: ;
    endcase
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic bit ref_match(input logic [7:0] h, s, m, hr, dy, dt);
    bit ok;
    ok = 1;
    if (a_h == 8'hFF) ok = 1;
    else if (a_h[7:4] == 4'hF) ok = (h[7:4] == a_h[3:0]);
    else ok = (h == a_h);
    if (!a_s[7]  && s[6:0]  != a_s[6:0])  ok = 0;
    if (!a_m[7]  && m[6:0]  != a_m[6:0])  ok = 0;
    if (!a_hr[7] && hr[6:0] != a_hr[6:0]) ok = 0;
    if (!a_dd[7]) begin
      if (a_dd[6]) begin if (dy[5:0] != a_dd[5:0]) ok = 0; end
      else         begin if (dt[5:0] != a_dd[5:0]) ok = 0; end
    end
    return ok;
  endfunction

  function automatic logic [7:0] rbcd(input int hi_max);
    return {4'($urandom % hi_max), 4'($urandom % 10)};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = $urandom(32'd7331);
    a_h = 0; a_s = 0; a_m = 0; a_hr = 0; a_dd = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 flag", alarm_flag, 0);
    check("R10 irq", irq_low, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: zeroed alarm bytes match an all-zero time (date 0)
    pulse_tick();
    check("R10 zero alarm regs hit zero time", alarm_flag, 1);
    check("R10 ctrl zero so irq released", irq_low, 0);
    wr(3'd6, 8'h00);
    check("R7 clear", alarm_flag, 0);

    // R2 every tick with all masks set
    wr(3'd0, 8'hFF); wr(3'd1, 8'h80); wr(3'd2, 8'h80); wr(3'd3, 8'h80); wr(3'd4, 8'h80);
    cur_hund = 8'h37; cur_sec = 8'h12;
    @(negedge clk);
    check("R6 no tick no set", alarm_flag, 0);
    pulse_tick();
    check("R2 FF every tick", alarm_flag, 1);
    // R7 write 1 no effect
    wr(3'd6, 8'h01);
    check("R7 write one keeps flag", alarm_flag, 1);
    // R8 enable truth table
    for (int c = 0; c < 8; c++) begin
      logic [7:0] cv;
      cv = {2'b00, c[2], 2'b00, c[1], 1'b0, c[0]};
      wr(3'd5, cv);
      check("R8 irq vs enables", irq_low, (c[0] && c[1]) ? 1 : 0);
    end
    // R9 battery mode
    wr(3'd5, 8'h05);
    batt_mode = 1'b1;
    #1 check("R9 batt released", irq_low, 0);
    wr(3'd5, 8'h25);
    check("R9 batt enabled drives", irq_low, 1);
    batt_mode = 1'b0;
    wr(3'd6, 8'h00);
    check("R8 cleared flag releases irq", irq_low, 0);

    // R7 set wins over clear in same cycle
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd6; wr_data = 8'h00;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R7 set beats clear", alarm_flag, 1);
    wr(3'd6, 8'h00);

    // R3 tenths only
    wr(3'd0, 8'hF3);
    cur_hund = 8'h39; pulse_tick();
    check("R3 tenths match", alarm_flag, 1);
    wr(3'd6, 8'h00);
    cur_hund = 8'h43; pulse_tick();
    check("R3 tenths mismatch", alarm_flag, 0);
    // R1 full byte
    wr(3'd0, 8'h43);
    pulse_tick();
    check("R1 exact", alarm_flag, 1);
    wr(3'd6, 8'h00);
    cur_hund = 8'h44; pulse_tick();
    check("R1 off by one", alarm_flag, 0);
    // R5 day vs date
    cur_hund = 8'h43; cur_day = 8'h03; cur_date = 8'h15;
    wr(3'd4, 8'h43);
    pulse_tick();
    check("R5 day select", alarm_flag, 1);
    wr(3'd6, 8'h00);
    wr(3'd4, 8'h03);
    pulse_tick();
    check("R5 date select ignores day", alarm_flag, 0);
    wr(3'd4, 8'h15);
    pulse_tick();
    check("R5 date select", alarm_flag, 1);
    wr(3'd6, 8'h00);

    // R4 random mix against reference
    for (int t = 0; t < 600; t++) begin
      logic [7:0] h, s, m, hr, dy, dt;
      int k;
      k = $urandom % 4;
      wr(3'd0, (k == 0) ? 8'hFF : (k == 1) ? {4'hF, 4'($urandom % 10)} : rbcd(10));
      wr(3'd1, {1'($urandom % 2), 1'b0, rbcd(6)[5:0]});
      wr(3'd2, {1'($urandom % 2), 1'b0, rbcd(6)[5:0]});
      wr(3'd3, {1'($urandom % 2), 1'($urandom % 2), 2'($urandom % 3), 4'($urandom % 10)});
      wr(3'd4, {1'($urandom % 2), 1'($urandom % 2), 2'($urandom % 4), 4'($urandom % 10)});
      h  = ($urandom % 3 != 0) ? ((a_h[7:4] == 4'hF) ? {a_h[3:0], 4'($urandom % 10)} : a_h) : rbcd(10);
      if (h == 8'hFF) h = 8'h99;
      s  = ($urandom % 4 != 0) ? {1'b0, a_s[6:0]} : {1'b0, rbcd(6)[6:0]};
      m  = ($urandom % 4 != 0) ? {1'b0, a_m[6:0]} : {1'b0, rbcd(6)[6:0]};
      hr = ($urandom % 4 != 0) ? {1'b0, a_hr[6:0]} : {1'b0, rbcd(3)[6:0]};
      dy = ($urandom % 3 != 0) ? {2'b00, a_dd[5:0]} : 8'(1 + $urandom % 7);
      dt = ($urandom % 3 != 0) ? {2'b00, a_dd[5:0]} : {2'b00, rbcd(4)[5:0]};
      cur_hund = h; cur_sec = s; cur_min = m; cur_hour = hr;
      cur_day = dy; cur_date = dt;
      pulse_tick();
      check("R4 masked compare vs reference", alarm_flag,
            ref_match(h, s, m, hr, dy, dt) ? 1 : 0);
      wr(3'd6, 8'h00);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule